// File: doc/BRIEF.md
# Load Queue with Store-Ordering Violation Detection

This block is the load side of an out-of-order memory pipeline. It keeps the in-flight loads in program order in a circular buffer, records each load's address once the load has executed, and checks every executing store against the younger loads that have already run. If such a load touched the same 256-byte region that the store writes, the load read stale data. The block then captures that load as the violator so that the pipeline can squash and refetch from it.

Loads enter at the tail with a sequence number and the store-queue tail seen at allocation. The block exposes its own tail index, which a store takes when it is allocated and returns when it executes. That index marks where the younger loads start. Retirement frees loads from the head. A pipeline flush removes loads from the tail. Each of these frees its whole set of loads in one cycle. The buffer uses one more slot than its capacity, so an empty queue and a full queue never show the same indices.

Top module: `lq_order_check`

## Requirements
- R1: After a synchronous active-high reset, `lq_count` is 0, `lq_tail` is 0, `viol_vld` is 0, `st_fault` is 0 and `viol_cnt` is 0.
- R2: The queue holds at most DEPTH loads. `lq_full` is 1 exactly when `lq_count` equals DEPTH. While full, `alloc_vld` is refused (`alloc_ok`=0) and the count does not change.
- R3: Each load keeps the store-queue tail given on `alloc_sq_tail` when it is allocated, and `viol_sq_tail` returns that value when the load is the violator.
- R4: A store with `st_lq_idx`=s scans only the slots from s forward in circular order up to, but not including, `lq_tail`. A load matches when `ld_addr[ADDR_W-1:8]` equals `st_addr[ADDR_W-1:8]`, so the low 8 bits are ignored. A load outside the scanned range never matches.
- R5: A load that has not yet executed through `ld_exec_vld` never matches.
- R6: When a store executes and nothing is latched, the match nearest to s in circular order is latched. In the next cycle `st_fault` is 1, `viol_vld` is 1, `viol_idx` and `viol_seq` identify that load, and `viol_cnt` has grown by one. With no match, `st_fault` is 0.
- R7: While a violator is latched, an executing store is not scanned: `st_fault` stays 0, and the latched violator and `viol_cnt` do not change.
- R8: A read (`viol_rd`=1) while `viol_vld`=1 clears `viol_vld` in the next cycle.
- R9: A retire (`commit_vld`) frees in one cycle every load from the head whose sequence number is at or below `commit_seq`.
- R10: A flush (`squash_vld`) frees in one cycle every load from the tail whose sequence number is above `squash_seq`. An allocation in the same cycle is dropped (`alloc_ok`=0).
- R11: Slot indices wrap after DEPTH+1 slots. With DEPTH=8, `lq_tail` goes from 8 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_tail | input | SQI_W | Store-queue tail captured by the new load |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| lq_tail | output | IDX_W | Tail slot index, captured by stores when they are allocated |
| lq_full | output | 1 | Queue holds DEPTH loads |
| lq_count | output | CNT_W | Number of loads held |
| ld_exec_vld | input | 1 | A load has executed; record its address |
| ld_exec_idx | input | IDX_W | Slot of the executed load |
| ld_exec_addr | input | ADDR_W | Address of the executed load |
| st_exec_vld | input | 1 | A store executes; scan the younger loads |
| st_lq_idx | input | IDX_W | Load tail captured by the store when it was allocated |
| st_addr | input | ADDR_W | Store address |
| st_fault | output | 1 | The previous store execution found a violation |
| viol_vld | output | 1 | A violator is latched |
| viol_idx | output | IDX_W | Slot of the violator |
| viol_seq | output | SEQ_W | Sequence number of the violator |
| viol_sq_tail | output | SQI_W | Store-queue tail captured by the violator |
| viol_rd | input | 1 | Read and clear the violator |
| viol_cnt | output | VCNT_W | Count of violations detected |
| commit_vld | input | 1 | Retire loads from the head |
| commit_seq | input | SEQ_W | Youngest retired sequence number |
| squash_vld | input | 1 | Flush loads from the tail |
| squash_seq | input | SEQ_W | Loads younger than this are removed |

## Verification
A wrong head, tail or count first shows at `lq_count`, `lq_tail` and `alloc_ok`, one edge after the retire, flush or allocation that caused it. It also shows later as the wrong slot in `viol_idx`, because the liveness mask decides which slots a store may match. A fault in the scan range, the address granule or the oldest-first choice appears in `st_fault` and `viol_idx` exactly one cycle after `st_exec_vld`. A fault in the latch hold or the clear appears on the next store or read, at `viol_vld` and `viol_cnt`. The bench keeps its own model of the queue and compares these ports after every edge, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/lq_pkg.sv
package lq_pkg;
    parameter int ADDR_W = 32;
    parameter int SEQ_W  = 16;
    parameter int SQI_W  = 4;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [SQI_W-1:0]  sq_tail;
        logic [ADDR_W-1:0] addr;
        logic              addr_ok;
    } lq_entry_t;

    // modular add for ring indices, b must not exceed n
    function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
        int unsigned s;
        s = a + b;
        return (s >= n) ? s - n : s;
    endfunction

    function automatic int unsigned ring_sub(int unsigned a, int unsigned b, int unsigned n);
        return ring_add(a, n - b, n);
    endfunction
endpackage

// File: rtl/lq_ring.sv
module lq_ring
    import lq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SLOTS = DEPTH + 1,
    parameter int IDX_W = $clog2(SLOTS),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_vld,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [SQI_W-1:0]  alloc_sq_tail,
    output logic              alloc_ok,
    input  logic              ld_exec_vld,
    input  logic [IDX_W-1:0]  ld_exec_idx,
    input  logic [ADDR_W-1:0] ld_exec_addr,
    input  logic              commit_vld,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_vld,
    input  logic [SEQ_W-1:0]  squash_seq,
    output lq_entry_t         ent_q [SLOTS],
    output logic [SLOTS-1:0]  live,
    output logic [IDX_W-1:0]  tail_q,
    output logic [CNT_W-1:0]  count_q
);
    typedef logic [IDX_W-1:0] idx_t;

    idx_t             head_q;
    logic [CNT_W-1:0] n_commit, n_squash;
    logic             exec_ok;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            live[i] = ring_sub(i, 32'(head_q), SLOTS) < 32'(count_q);
        end
    end

    // sequence numbers rise along the ring, so a count picks the prefix/suffix
    always_comb begin
        n_commit = '0;
        n_squash = '0;
        for (int i = 0; i < SLOTS; i++) begin
            n_commit = n_commit + CNT_W'(live[i] && commit_vld && (ent_q[i].seq <= commit_seq));
            n_squash = n_squash + CNT_W'(live[i] && squash_vld && (ent_q[i].seq > squash_seq));
        end
    end

    assign alloc_ok = alloc_vld && (count_q != CNT_W'(DEPTH)) && !squash_vld;
    assign exec_ok  = ld_exec_vld && (32'(ld_exec_idx) < SLOTS) && live[ld_exec_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= idx_t'(ring_add(32'(head_q), 32'(n_commit), SLOTS));
            tail_q  <= idx_t'(ring_add(ring_sub(32'(tail_q), 32'(n_squash), SLOTS),
                                       32'(alloc_ok), SLOTS));
            count_q <= count_q - n_commit - n_squash + CNT_W'(alloc_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) ent_q[i] <= '0;
        end else begin
            if (alloc_ok) begin
                ent_q[tail_q].seq     <= alloc_seq;
                ent_q[tail_q].sq_tail <= alloc_sq_tail;
                ent_q[tail_q].addr    <= '0;
                ent_q[tail_q].addr_ok <= 1'b0;
            end
            if (exec_ok) begin
                ent_q[ld_exec_idx].addr    <= ld_exec_addr;
                ent_q[ld_exec_idx].addr_ok <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lq_scan.sv
module lq_scan
    import lq_pkg::*;
#(
    parameter int SLOTS     = 9,
    parameter int IDX_W     = 4,
    parameter int GRAN_BITS = 8
) (
    input  lq_entry_t         ent_q [SLOTS],
    input  logic [SLOTS-1:0]  live,
    input  logic [IDX_W-1:0]  tail_q,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [SEQ_W-1:0]  hit_seq,
    output logic [SQI_W-1:0]  hit_sqt
);
    typedef logic [IDX_W-1:0] idx_t;

    logic [SLOTS-1:0] match;
    logic             open;
    idx_t             j;

    // per-slot compare on the coarse granule, only for executed live loads
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            match[i] = live[i] && ent_q[i].addr_ok &&
                       (ent_q[i].addr[ADDR_W-1:GRAN_BITS] == st_addr[ADDR_W-1:GRAN_BITS]);
        end
    end

    // walk from the captured index toward the tail, first hit wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        open    = 32'(st_idx) < SLOTS;
        for (int k = 0; k < SLOTS; k++) begin
            j = idx_t'(ring_add(32'(st_idx) % SLOTS, k, SLOTS));
            if (j == tail_q) open = 1'b0;
            if (open && !hit && match[j]) begin
                hit     = 1'b1;
                hit_idx = j;
            end
        end
        hit_seq = ent_q[hit_idx].seq;
        hit_sqt = ent_q[hit_idx].sq_tail;
    end
endmodule

// File: rtl/lq_viol.sv
module lq_viol
    import lq_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int VCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_exec_vld,
    input  logic              hit,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic [SEQ_W-1:0]  hit_seq,
    input  logic [SQI_W-1:0]  hit_sqt,
    input  logic              viol_rd,
    output logic              st_fault,
    output logic              viol_vld,
    output logic [IDX_W-1:0]  viol_idx,
    output logic [SEQ_W-1:0]  viol_seq,
    output logic [SQI_W-1:0]  viol_sq_tail,
    output logic [VCNT_W-1:0] viol_cnt
);
    logic take;
    assign take = st_exec_vld && !viol_vld && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_fault     <= 1'b0;
            viol_vld     <= 1'b0;
            viol_idx     <= '0;
            viol_seq     <= '0;
            viol_sq_tail <= '0;
            viol_cnt     <= '0;
        end else begin
            st_fault <= take;
            if (take) begin
                viol_vld     <= 1'b1;
                viol_idx     <= hit_idx;
                viol_seq     <= hit_seq;
                viol_sq_tail <= hit_sqt;
                viol_cnt     <= viol_cnt + VCNT_W'(1);
            end else if (viol_rd && viol_vld) begin
                viol_vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lq_order_check.sv
module lq_order_check
    import lq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int GRAN_BITS = 8,
    parameter int VCNT_W    = 16,
    localparam int SLOTS    = DEPTH + 1,
    localparam int IDX_W    = $clog2(SLOTS),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_vld,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [SQI_W-1:0]  alloc_sq_tail,
    output logic              alloc_ok,
    output logic [IDX_W-1:0]  lq_tail,
    output logic              lq_full,
    output logic [CNT_W-1:0]  lq_count,
    input  logic              ld_exec_vld,
    input  logic [IDX_W-1:0]  ld_exec_idx,
    input  logic [ADDR_W-1:0] ld_exec_addr,
    input  logic              st_exec_vld,
    input  logic [IDX_W-1:0]  st_lq_idx,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              st_fault,
    output logic              viol_vld,
    output logic [IDX_W-1:0]  viol_idx,
    output logic [SEQ_W-1:0]  viol_seq,
    output logic [SQI_W-1:0]  viol_sq_tail,
    input  logic              viol_rd,
    output logic [VCNT_W-1:0] viol_cnt,
    input  logic              commit_vld,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_vld,
    input  logic [SEQ_W-1:0]  squash_seq
);
    lq_entry_t        ent_q [SLOTS];
    logic [SLOTS-1:0] live;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [SEQ_W-1:0] hit_seq;
    logic [SQI_W-1:0] hit_sqt;

    lq_ring #(.DEPTH(DEPTH), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
        .clk, .rst, .alloc_vld, .alloc_seq, .alloc_sq_tail, .alloc_ok,
        .ld_exec_vld, .ld_exec_idx, .ld_exec_addr,
        .commit_vld, .commit_seq, .squash_vld, .squash_seq,
        .ent_q, .live, .tail_q(lq_tail), .count_q(lq_count)
    );

    lq_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .GRAN_BITS(GRAN_BITS)) u_scan (
        .ent_q, .live, .tail_q(lq_tail), .st_idx(st_lq_idx), .st_addr,
        .hit, .hit_idx, .hit_seq, .hit_sqt
    );

    lq_viol #(.IDX_W(IDX_W), .VCNT_W(VCNT_W)) u_viol (
        .clk, .rst, .st_exec_vld, .hit, .hit_idx, .hit_seq, .hit_sqt, .viol_rd,
        .st_fault, .viol_vld, .viol_idx, .viol_seq, .viol_sq_tail, .viol_cnt
    );

    assign lq_full = (lq_count == CNT_W'(DEPTH));
endmodule

// File: rtl/lq_order_check_sva.sv
module lq_order_check_sva
    import lq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 4,
    parameter int VCNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_ok,
    input logic              lq_full,
    input logic [CNT_W-1:0]  lq_count,
    input logic              squash_vld,
    input logic              st_exec_vld,
    input logic              st_fault,
    input logic              viol_vld,
    input logic              viol_rd,
    input logic [IDX_W-1:0]  viol_idx,
    input logic [SEQ_W-1:0]  viol_seq,
    input logic [VCNT_W-1:0] viol_cnt
);
    a_r2_full_refuses: assert property (@(posedge clk) disable iff (rst)
        lq_full |-> !alloc_ok);
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        32'(lq_count) <= DEPTH);
    a_r10_flush_drops_alloc: assert property (@(posedge clk) disable iff (rst)
        squash_vld |-> !alloc_ok);
    a_r6_fault_after_exec: assert property (@(posedge clk) disable iff (rst)
        st_fault |-> $past(st_exec_vld) && viol_vld && !$past(viol_vld));
    a_r6_cnt_steps: assert property (@(posedge clk) disable iff (rst)
        st_fault |-> viol_cnt == VCNT_W'($past(viol_cnt) + VCNT_W'(1)));
    a_r6_cnt_holds: assert property (@(posedge clk) disable iff (rst)
        !st_fault |-> $stable(viol_cnt));
    a_r7_latch_holds: assert property (@(posedge clk) disable iff (rst)
        viol_vld && !viol_rd |=> viol_vld && $stable(viol_idx) && $stable(viol_seq));
    a_r7_no_fault_latched: assert property (@(posedge clk) disable iff (rst)
        viol_vld |=> !st_fault);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        viol_vld && viol_rd |=> !viol_vld);
endmodule

bind lq_order_check lq_order_check_sva #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .VCNT_W(VCNT_W)
) u_sva (.*);

// File: tb/tb_lq_order_check.sv
module tb_lq_order_check;
    localparam int CLK_PERIOD = 10;
    localparam int D  = 8;
    localparam int SL = D + 1;

    logic        clk = 1'b0, rst = 1'b1;
    logic        alloc_vld = 0, ld_exec_vld = 0, st_exec_vld = 0, viol_rd = 0;
    logic        commit_vld = 0, squash_vld = 0;
    logic [15:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
    logic [3:0]  alloc_sq_tail = 0, ld_exec_idx = 0, st_lq_idx = 0;
    logic [31:0] ld_exec_addr = 0, st_addr = 0;
    logic        alloc_ok, lq_full, st_fault, viol_vld;
    logic [3:0]  lq_tail, lq_count, viol_idx, viol_sq_tail;
    logic [15:0] viol_seq, viol_cnt;

    lq_order_check dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int m_seq [SL], m_sqt [SL];
    logic [31:0] m_addr [SL];
    bit m_ok [SL];
    int m_head = 0, m_tail = 0, m_cnt = 0;
    bit m_vv = 0, m_fault = 0;
    int m_vidx = 0, m_vseq = 0, m_vsqt = 0, m_vcnt = 0;
    int nseq = 1;

    task automatic cmp(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic bit live_m(int i);
        return ((i - m_head + SL) % SL) < m_cnt;
    endfunction

    function automatic bit alloc_exp();
        return alloc_vld && (m_cnt < D) && !squash_vld;
    endfunction

    // one clock: predict, clock, compare; inputs are driven at the negedge before
    task automatic step();
        int nc, ns, hidx, j;
        bit aok, hit, open;
        #1;
        aok = alloc_exp();
        cmp("R2 R10 alloc_ok", alloc_ok, aok);
        cmp("R2 lq_full", lq_full, m_cnt == D);
        hit = 0; hidx = 0;
        if (st_exec_vld && !m_vv) begin
            open = 1;
            for (int k = 0; k < SL; k++) begin
                j = (int'(st_lq_idx) + k) % SL;
                if (j == m_tail) open = 0;
                if (open && !hit && live_m(j) && m_ok[j] && (m_addr[j] >> 8) == (st_addr >> 8)) begin
                    hit = 1; hidx = j;
                end
            end
        end
        nc = 0; ns = 0;
        for (int i = 0; i < SL; i++) if (live_m(i)) begin
            if (commit_vld && m_seq[i] <= int'(commit_seq)) nc++;
            if (squash_vld && m_seq[i] > int'(squash_seq)) ns++;
        end
        if (ld_exec_vld && live_m(ld_exec_idx)) begin
            m_addr[ld_exec_idx] = ld_exec_addr;
            m_ok[ld_exec_idx] = 1;
        end
        if (aok) begin
            m_seq[m_tail] = alloc_seq; m_sqt[m_tail] = alloc_sq_tail; m_ok[m_tail] = 0;
        end
        m_fault = hit;
        if (hit) begin
            m_vv = 1; m_vidx = hidx; m_vseq = m_seq[hidx]; m_vsqt = m_sqt[hidx]; m_vcnt++;
        end else if (viol_rd && m_vv) m_vv = 0;
        m_head = (m_head + nc) % SL;
        m_tail = (m_tail - ns + SL + int'(aok)) % SL;
        m_cnt  = m_cnt - nc - ns + int'(aok);
        @(posedge clk); #1;
        cmp("R2 R9 R10 lq_count", lq_count, m_cnt);
        cmp("R11 lq_tail", lq_tail, m_tail);
        cmp("R4 R6 st_fault", st_fault, m_fault);
        cmp("R7 R8 viol_vld", viol_vld, m_vv);
        if (m_vv) begin
            cmp("R6 viol_idx", viol_idx, m_vidx);
            cmp("R6 viol_seq", viol_seq, m_vseq);
            cmp("R3 viol_sq_tail", viol_sq_tail, m_vsqt);
        end
        cmp("R6 viol_cnt", viol_cnt, m_vcnt);
        @(negedge clk);
        alloc_vld = 0; ld_exec_vld = 0; st_exec_vld = 0; viol_rd = 0;
        commit_vld = 0; squash_vld = 0;
    endtask

    task automatic alloc(int s, int t);
        alloc_vld = 1; alloc_seq = 16'(s); alloc_sq_tail = 4'(t); step();
    endtask
    task automatic ldx(int i, logic [31:0] a);
        ld_exec_vld = 1; ld_exec_idx = 4'(i); ld_exec_addr = a; step();
    endtask
    task automatic stx(int i, logic [31:0] a);
        st_exec_vld = 1; st_lq_idx = 4'(i); st_addr = a; step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < SL; i++) begin m_seq[i] = 0; m_sqt[i] = 0; m_addr[i] = 0; m_ok[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        cmp("R1 lq_count", lq_count, 0);
        cmp("R1 lq_tail", lq_tail, 0);
        cmp("R1 viol_vld", viol_vld, 0);
        cmp("R1 st_fault", st_fault, 0);
        cmp("R1 viol_cnt", viol_cnt, 0);
        @(negedge clk); rst = 0;

        alloc(1, 5); alloc(2, 6); alloc(3, 7);
        cmp("R2 three held", lq_count, 3);
        ldx(1, 32'h1234); ldx(2, 32'h12FF);
        stx(0, 32'h1200);   // slot0 unexecuted: R5; slot1 oldest executed match
        cmp("R5 R6 first violator", viol_idx, 1);
        cmp("R3 captured sq tail", viol_sq_tail, 6);
        cmp("R6 fault seen", st_fault, 1);
        stx(2, 32'h12AA);
        cmp("R7 no rescan", st_fault, 0);
        cmp("R7 violator kept", viol_idx, 1);
        cmp("R7 count kept", viol_cnt, 1);
        viol_rd = 1; step();
        cmp("R8 cleared", viol_vld, 0);
        stx(2, 32'h1300);
        cmp("R4 other granule", st_fault, 0);
        stx(3, 32'h1200);
        cmp("R4 empty range", st_fault, 0);
        ldx(0, 32'h5500);
        stx(1, 32'h5510);
        cmp("R4 older load outside range", st_fault, 0);
        stx(0, 32'h12C0);
        cmp("R6 second violator", viol_idx, 1);
        cmp("R6 count two", viol_cnt, 2);
        viol_rd = 1; step();
        alloc_vld = 1; alloc_seq = 9; squash_vld = 1; squash_seq = 1; step();
        cmp("R10 flush", lq_count, 1);
        cmp("R10 flush tail", lq_tail, 1);
        commit_vld = 1; commit_seq = 1; step();
        cmp("R9 retire", lq_count, 0);
        for (int s = 10; s < 18; s++) alloc(s, s % 16);
        cmp("R2 full", lq_full, 1);
        alloc(18, 0);
        cmp("R2 refused", lq_count, 8);
        cmp("R11 wrapped tail", lq_tail, 0);
        commit_vld = 1; commit_seq = 13; step();
        cmp("R9 multi retire", lq_count, 4);
        squash_vld = 1; squash_seq = 15; step();
        cmp("R10 multi flush", lq_count, 2);
        commit_vld = 1; commit_seq = 20; step();
        nseq = 100;

        for (int n = 0; n < 4000; n++) begin
            bit acc;
            alloc_vld = ($urandom % 3) != 0;
            alloc_seq = 16'(nseq);
            alloc_sq_tail = 4'($urandom % 16);
            if (m_cnt > 0 && ($urandom % 2) == 0) begin
                ld_exec_vld = 1;
                ld_exec_idx = 4'((m_head + int'($urandom % m_cnt)) % SL);
                ld_exec_addr = (($urandom % 4) << 8) | ($urandom % 256);
            end
            if (($urandom % 3) == 0) begin
                st_exec_vld = 1;
                st_lq_idx = 4'((m_head + int'($urandom % (m_cnt + 1))) % SL);
                st_addr = (($urandom % 4) << 8) | ($urandom % 256);
            end
            viol_rd = ($urandom % 4) == 0;
            if (m_cnt > 0 && ($urandom % 6) == 0) begin
                commit_vld = 1;
                commit_seq = 16'(m_seq[m_head] + int'($urandom % 3));
            end else if (m_cnt > 0 && ($urandom % 10) == 0) begin
                squash_vld = 1;
                squash_seq = 16'(nseq - 1 - int'($urandom % 3));
            end
            acc = alloc_exp();
            step();
            if (acc) nseq++;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule